// File: doc/BRIEF.md
# Flash word-program command front end

This block models the command side of a NOR-style flash device on a plain synchronous bus. A write of a setup opcode in the low byte of the data bus, followed by a second write that carries the target address and data word, starts a word program. Before the program is allowed to run, the block checks two things. The target block must not be locked, and the programming-supply-good input must be high. If both hold, the block holds a busy state for a set number of cycles and then merges the data into a small internal array.

Once a program or setup command has been written, reads return an 8-bit status byte until a read-array command is written. Error flags in the status byte stay set until a clear-status command is written. The two buffered-style program sequences, an ordinary buffered setup and a factory setup, are decoded. Each is followed by a confirm write, and each is then refused with its own status pattern. The block also reports which programming region the most recent target address falls in. A region is a group of 8 or 16 blocks, chosen by a parameter.

States: `ST_IDLE` accepts commands. `ST_WP_DATA` waits for the address/data write of a word program. `ST_BUF_CONFIRM` and `ST_EFP_CONFIRM` wait for the confirm write of a buffered or factory sequence. `ST_BUSY` counts down the program time. The transitions are as follows:
- `ST_IDLE` goes to `ST_WP_DATA` on opcode 40h or 10h, to `ST_BUF_CONFIRM` on E8h, and to `ST_EFP_CONFIRM` on 80h.
- `ST_WP_DATA` goes to `ST_BUSY` when the checks pass, and back to `ST_IDLE` when they fail.
- Both confirm states always return to `ST_IDLE` on the next write.
- `ST_BUSY` returns to `ST_IDLE` when the timer expires, and the array write happens on that same edge.

Top module: `flash_pgm_front`

## Requirements
- R1: Writing 40h or 10h (low byte of `wdata`) in idle, then a second write, programs the array word at that second write's `addr` with the new value `old & wdata` once the busy time ends. Bits can only go from 1 to 0.
- R2: After a program, buffered, factory or read-status (70h) command, each read returns `{zeros, SR}` one cycle after `rd_en`. SR bit 7 is the ready flag, bit 5 is sequence/unsupported, bit 4 is program error, bit 3 is supply error, bit 2 is factory-sequence marker, bit 1 is block-locked, and bits 6 and 0 read 0.
- R3: SR bit 7 reads 0 for `BUSY_CYCLES` cycles after an accepted data write, and 1 otherwise.
- R4: If the block `addr[ADDR_W-1:BLOCK_W]` has its `blk_lock` bit set at the data write, the array is not changed and SR bits 4 and 1 are set.
- R5: If `vpp_ok` is low at the data write, the array is not changed and SR bits 4 and 3 are set. Both R4 and R5 checks apply together.
- R6: E8h followed by a D0h confirm is refused: SR bit 5 is set and the array is unchanged.
- R7: 80h followed by a D0h confirm is refused: SR bits 5 and 2 are set.
- R8: If the write after E8h or 80h is not D0h, SR bits 5 and 4 are set.
- R9: SR bits 6..0 stay set until a 50h clear-status command is written in idle, which clears them.
- R10: Writing FFh in idle makes later reads return array data.
- R11: Any write while busy is ignored. This includes FFh, 50h and setup opcodes.
- R12: `region_idx` equals the block number of the last data write divided by `REGION_BLOCKS` (8 or 16). It is updated on that write whether or not the write is accepted.
- R13: After reset the array is all ones, reads return array data, SR is 80h, and `region_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data; opcode in bits 7:0 |
| vpp_ok | input | 1 | Programming supply above lockout |
| blk_lock | input | 2**(ADDR_W-BLOCK_W) | Per-block lock bits |
| rdata | output | DATA_W | Registered read data or status |
| region_idx | output | ADDR_W-BLOCK_W-log2(REGION_BLOCKS) | Region of last target address |

## Verification
The hardest situation to reach from the ports is a command written in the middle of a program, because the ignore rule can only be seen through what happens afterwards. The bench therefore writes FFh and then a 40h setup during the busy window. It first confirms that reads still return a busy status. After the program finishes, it issues a plain data write to a new word. Had the stray setup been accepted, that write would have programmed the word, so reading the array back shows whether the busy-time writes were really dropped. Sticky error flags are reached the same way: a locked-block abort is followed by a successful program, and the bench checks that the old flags are still set.

// File: rtl/flash_pgm_pkg.sv
package flash_pgm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WP_DATA,
        ST_BUF_CONFIRM,
        ST_EFP_CONFIRM,
        ST_BUSY
    } state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_WORD_PGM,
        OP_BUF_SETUP,
        OP_EFP_SETUP,
        OP_CONFIRM,
        OP_CLR_SR,
        OP_RD_SR,
        OP_RD_ARRAY
    } op_e;

    localparam int SR_READY = 7;
    localparam int SR_SEQ   = 5;
    localparam int SR_PGM   = 4;
    localparam int SR_VPP   = 3;
    localparam int SR_EFP   = 2;
    localparam int SR_LOCK  = 1;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_pgm_pkg::*;
(
    input  logic [7:0] opcode,
    output op_e        op
);
    always_comb begin
        unique case (opcode)
            8'h40, 8'h10: op = OP_WORD_PGM;
            8'hE8:        op = OP_BUF_SETUP;
            8'h80:        op = OP_EFP_SETUP;
            8'hD0:        op = OP_CONFIRM;
            8'h50:        op = OP_CLR_SR;
            8'h70:        op = OP_RD_SR;
            8'hFF:        op = OP_RD_ARRAY;
            default:      op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
    parameter int CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CNT_W'(CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign done = (cnt == CNT_W'(1));
endmodule

// File: rtl/flash_word_array.sv
module flash_word_array #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
        end else if (we) begin
            mem[waddr] <= mem[waddr] & wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/flash_pgm_front.sv
module flash_pgm_front
    import flash_pgm_pkg::*;
#(
    parameter int ADDR_W        = 9,
    parameter int DATA_W        = 16,
    parameter int BLOCK_W       = 4,
    parameter int REGION_BLOCKS = 8,
    parameter int BUSY_CYCLES   = 20,
    localparam int BLK_W        = ADDR_W - BLOCK_W,
    localparam int NUM_BLOCKS   = 1 << BLK_W,
    localparam int REG_SHIFT    = $clog2(REGION_BLOCKS),
    localparam int REGION_W     = BLK_W - REG_SHIFT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  vpp_ok,
    input  logic [NUM_BLOCKS-1:0] blk_lock,
    output logic [DATA_W-1:0]     rdata,
    output logic [REGION_W-1:0]   region_idx
);
    state_e              state, state_n;
    op_e                 op;
    logic [6:0]          sr_err, err_set;
    logic                status_mode;
    logic                start_pgm;
    logic                timer_done;
    logic                mem_we;
    logic                locked_hit;
    logic                clr_accept;
    logic [ADDR_W-1:0]   tgt_addr;
    logic [DATA_W-1:0]   tgt_data;
    logic [DATA_W-1:0]   arr_rdata;
    logic [7:0]          sr;

    flash_cmd_decode u_dec (
        .opcode (wdata[7:0]),
        .op     (op)
    );

    flash_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start_pgm),
        .done  (timer_done)
    );

    flash_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (tgt_addr),
        .wdata (tgt_data),
        .raddr (addr),
        .rdata (arr_rdata)
    );

    assign locked_hit = blk_lock[addr[ADDR_W-1:BLOCK_W]];
    assign mem_we     = (state == ST_BUSY) && timer_done;
    assign clr_accept = (state == ST_IDLE) && wr_en && (op == OP_CLR_SR);
    assign sr         = {(state != ST_BUSY), sr_err};

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // Next state and error flags raised by this write
    always_comb begin
        state_n   = state;
        start_pgm = 1'b0;
        err_set   = '0;
        unique case (state)
            ST_IDLE: begin
                if (wr_en) begin
                    unique case (op)
                        OP_WORD_PGM:  state_n = ST_WP_DATA;
                        OP_BUF_SETUP: state_n = ST_BUF_CONFIRM;
                        OP_EFP_SETUP: state_n = ST_EFP_CONFIRM;
                        default:      state_n = ST_IDLE;
                    endcase
                end
            end
            ST_WP_DATA: begin
                if (wr_en) begin
                    if (locked_hit || !vpp_ok) begin
                        err_set[SR_PGM]  = 1'b1;
                        err_set[SR_LOCK] = locked_hit;
                        err_set[SR_VPP]  = !vpp_ok;
                        state_n          = ST_IDLE;
                    end else begin
                        start_pgm = 1'b1;
                        state_n   = ST_BUSY;
                    end
                end
            end
            ST_BUF_CONFIRM: begin
                if (wr_en) begin
                    err_set[SR_SEQ] = 1'b1;
                    err_set[SR_PGM] = (op != OP_CONFIRM);
                    state_n         = ST_IDLE;
                end
            end
            ST_EFP_CONFIRM: begin
                if (wr_en) begin
                    err_set[SR_SEQ] = 1'b1;
                    err_set[SR_PGM] = (op != OP_CONFIRM);
                    err_set[SR_EFP] = (op == OP_CONFIRM);
                    state_n         = ST_IDLE;
                end
            end
            ST_BUSY: begin
                if (timer_done) begin
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // Registered outputs and status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_err      <= '0;
            status_mode <= 1'b0;
            tgt_addr    <= '0;
            tgt_data    <= '1;
            region_idx  <= '0;
            rdata       <= '0;
        end else begin
            if (clr_accept) begin
                sr_err <= '0;
            end else begin
                sr_err <= sr_err | err_set;
            end

            if (state == ST_IDLE && wr_en) begin
                unique case (op)
                    OP_WORD_PGM, OP_BUF_SETUP, OP_EFP_SETUP, OP_RD_SR:
                        status_mode <= 1'b1;
                    OP_RD_ARRAY:
                        status_mode <= 1'b0;
                    default: ;
                endcase
            end

            if (state == ST_WP_DATA && wr_en) begin
                tgt_addr   <= addr;
                tgt_data   <= wdata;
                region_idx <= addr[ADDR_W-1:BLOCK_W+REG_SHIFT];
            end

            if (rd_en) begin
                rdata <= status_mode ? {{(DATA_W-8){1'b0}}, sr} : arr_rdata;
            end
        end
    end
endmodule

// File: rtl/flash_pgm_front_chk.sv
module flash_pgm_front_chk
    import flash_pgm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       vpp_ok,
    input state_e     state,
    input op_e        op,
    input logic       locked_hit,
    input logic [6:0] sr_err,
    input logic       mem_we,
    input logic       timer_done,
    input logic       clr_accept
);
    AST_WP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && wr_en && op == OP_WORD_PGM) |=> (state == ST_WP_DATA)); // R1

    AST_COMMIT_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (state == ST_IDLE)); // R3

    AST_LOCK_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WP_DATA && wr_en && locked_hit)
        |=> (sr_err[SR_PGM] && sr_err[SR_LOCK] && state == ST_IDLE)); // R4

    AST_VPP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WP_DATA && wr_en && !vpp_ok)
        |=> (sr_err[SR_PGM] && sr_err[SR_VPP] && state == ST_IDLE)); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((~sr_err & $past(sr_err)) != 7'd0) |-> $past(clr_accept)); // R9

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && !timer_done) |=> (state == ST_BUSY)); // R11
endmodule

bind flash_pgm_front flash_pgm_front_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .vpp_ok     (vpp_ok),
    .state      (state),
    .op         (op),
    .locked_hit (locked_hit),
    .sr_err     (sr_err),
    .mem_we     (mem_we),
    .timer_done (timer_done),
    .clr_accept (clr_accept)
);

// File: tb/flash_pgm_front_test.sv
`timescale 1ns/1ps
module flash_pgm_front_test;
    localparam int ADDR_W = 9;
    localparam int DATA_W = 16;
    localparam int BUSY   = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic              vpp_ok = 1'b1;
    logic [31:0]       blk_lock = '0;
    logic [DATA_W-1:0] rdata;
    logic [1:0]        region_idx;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    flash_pgm_front #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLOCK_W(4),
        .REGION_BLOCKS(8), .BUSY_CYCLES(BUSY)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .vpp_ok(vpp_ok), .blk_lock(blk_lock),
        .rdata(rdata), .region_idx(region_idx)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic bus_wr(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic read_array(logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        bus_wr('0, 16'h00FF);
        bus_rd(a, d);
    endtask

    task automatic t_reset();
        logic [DATA_W-1:0] d;
        bus_rd(9'd3, d);
        check("R13 array erased", d, 16'hFFFF);
        check("R13 region", region_idx, 2'd0);
        bus_wr('0, 16'h0070);
        bus_rd('0, d);
        check("R13 status after reset", d, 16'h0080);
    endtask

    task automatic t_word();
        logic [DATA_W-1:0] d;
        bus_wr('0, 16'h0040);
        bus_wr(9'h10A, 16'h1234);
        bus_rd('0, d);
        check("R3 busy status", d, 16'h0000);
        idle(BUSY + 2);
        bus_rd('0, d);
        check("R2 ready status", d, 16'h0080);
        read_array(9'h10A, d);
        check("R1 programmed word", d, 16'h1234);
        check("R12 region 2", region_idx, 2'd2);
        check("R10 array mode", d, 16'h1234);
    endtask

    task automatic t_and();
        logic [DATA_W-1:0] d;
        bus_wr('0, 16'h0010);
        bus_wr(9'h10A, 16'hFF0F);
        idle(BUSY + 2);
        read_array(9'h10A, d);
        check("R1 and-merge", d, 16'h1204);
    endtask

    task automatic t_lock();
        logic [DATA_W-1:0] d;
        blk_lock[5] = 1'b1;
        bus_wr('0, 16'h0040);
        bus_wr(9'h052, 16'h0000);
        bus_rd('0, d);
        check("R4 lock status", d, 16'h0092);
        check("R12 region 0", region_idx, 2'd0);
        read_array(9'h052, d);
        check("R4 array untouched", d, 16'hFFFF);
        blk_lock[5] = 1'b0;
    endtask

    task automatic t_sticky();
        logic [DATA_W-1:0] d;
        bus_wr('0, 16'h0040);
        bus_wr(9'h1F0, 16'hAAAA);
        idle(BUSY + 2);
        bus_rd('0, d);
        check("R9 flags kept", d, 16'h0092);
        check("R12 region 3", region_idx, 2'd3);
        bus_wr('0, 16'h0050);
        bus_rd('0, d);
        check("R9 cleared", d, 16'h0080);
        read_array(9'h1F0, d);
        check("R1 program after abort", d, 16'hAAAA);
    endtask

    task automatic t_vpp();
        logic [DATA_W-1:0] d;
        vpp_ok = 1'b0;
        bus_wr('0, 16'h0040);
        bus_wr(9'h030, 16'h0000);
        vpp_ok = 1'b1;
        bus_rd('0, d);
        check("R5 supply status", d, 16'h0098);
        read_array(9'h030, d);
        check("R5 array untouched", d, 16'hFFFF);
        bus_wr('0, 16'h0050);
    endtask

    task automatic t_buffered();
        logic [DATA_W-1:0] d;
        bus_wr('0, 16'h00E8);
        bus_wr(9'h040, 16'h00D0);
        bus_rd('0, d);
        check("R6 buffered refused", d, 16'h00A0);
        bus_wr('0, 16'h0050);
        bus_wr('0, 16'h0080);
        bus_wr(9'h040, 16'h00D0);
        bus_rd('0, d);
        check("R7 factory refused", d, 16'h00A4);
        bus_wr('0, 16'h0050);
        bus_wr('0, 16'h00E8);
        bus_wr(9'h040, 16'h0055);
        bus_rd('0, d);
        check("R8 bad confirm", d, 16'h00B0);
        bus_wr('0, 16'h0050);
        read_array(9'h040, d);
        check("R6 array untouched", d, 16'hFFFF);
    endtask

    task automatic t_busy_ignore();
        logic [DATA_W-1:0] d;
        bus_wr('0, 16'h0040);
        bus_wr(9'h020, 16'h00F0);
        bus_wr('0, 16'h00FF);
        bus_rd('0, d);
        check("R11 read-array ignored while busy", d, 16'h0000);
        bus_wr('0, 16'h0040);
        idle(BUSY + 2);
        bus_rd('0, d);
        check("R11 ready after", d, 16'h0080);
        bus_wr(9'h021, 16'h0000);
        read_array(9'h021, d);
        check("R11 setup ignored", d, 16'hFFFF);
        bus_rd(9'h020, d);
        check("R1 busy-window program", d, 16'h00F0);
    endtask

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_word();
        t_and();
        t_lock();
        t_sticky();
        t_vpp();
        t_buffered();
        t_busy_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule